// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block is a three-wire serial slave that fills a bank of eight 24-bit control registers. A host shifts a word in on a serial clock and data line, most significant bit first, and then raises a load strobe. The three least significant bits of the word choose which register receives the whole word. All three serial lines are asynchronous to the system clock. They are brought into that clock domain through two-stage synchronisers, and their edges are detected there.

Registers 0, 1 and 2 hold the frequency settings. A write to any of them starts a frequency calibration. The block then holds a busy output high until the calibration engine, which lies outside this block, reports completion. The block also chooses the local-oscillator path. It combines two external pins, a PLL-enable pin and a driver-enable pin, with two bits of register 5. The result says whether the internal oscillator feeds the mixer and whether the oscillator output buffer is on.

A load whose bit count is not exactly 24 is dropped, and the block raises an error flag.

Top module: `serial_ctrl_bank`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock and shifted in MSB first. A 24-bit word appears in its register exactly as sent, with bit 23 first on the wire.
- R2: Word bits [2:0] select the destination register 0..7. The full 24-bit word, including those bits, is stored there, and every other register keeps its value.
- R3: A register changes only on a rising edge of the load strobe. Shifting bits without that edge leaves every register unchanged.
- R4: A load after a bit count other than 24, whether fewer or more, writes no register and sets frame_err to 1. The next load of exactly 24 bits clears frame_err to 0.
- R5: After reset, registers 0-4, 6 and 7 are zero and register 5 is 0x000040 (bit 6 set). cal_busy and frame_err are 0.
- R6: A valid write to register 0, 1 or 2 sets cal_busy in the cycle after the load. A write to registers 3-7 does not set cal_busy.
- R7: cal_busy clears in the cycle after cal_done is high. A new write to register 0-2 while busy keeps cal_busy high until cal_done. A trigger in the same cycle as cal_done wins, and cal_busy stays high.
- R8: lo_internal is 1 only when pll_en_pin is 1 and register 5 bit 6 is 1. Otherwise it is 0, which selects the external oscillator.
- R9: lo_buf_en is 1 only when lo_internal is 1 and either drv_en_pin or register 5 bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least five times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous, active on its rising edge |
| pll_en_pin | input | 1 | External PLL-enable pin |
| drv_en_pin | input | 1 | External oscillator-buffer enable pin |
| cal_done | input | 1 | Calibration finished, from the calibration engine |
| ctrl_regs | output | 192 | All registers; register i is at bits [24*i+23 : 24*i] |
| frame_err | output | 1 | Last load had a bit count other than 24 |
| cal_busy | output | 1 | Calibration pending or running |
| lo_internal | output | 1 | Mixer oscillator comes from the internal PLL |
| lo_buf_en | output | 1 | Oscillator output buffer drives the LO pins |

## Verification
The hardest condition to reach from the ports is a load strobe that arrives after the wrong number of serial clocks. This matters most when the trailing 24 bits of an overlong frame would make a perfectly valid word. The bench's serial task takes an explicit bit count, so it sends 20-bit and 28-bit frames whose last 24 bits address a live register, and then checks that the register kept its value. Calibration restart is reached by writing a second frequency register while busy is still high, and holding cal_done low until after that second write has landed.

// File: rtl/scb_pkg.sv
package scb_pkg;
    parameter int WORD_W      = 24;
    parameter int NREG        = 8;
    parameter int ADDR_W      = $clog2(NREG);
    parameter int NUM_CAL_REG = 3;
    parameter int LO_REG      = 5;
    parameter int PLEN_BIT    = 6;
    parameter int LDRV_BIT    = 3;
    parameter int CNT_W       = $clog2(WORD_W + 2);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } load_t;

    typedef enum logic [2:0] {
        PIN_SCLK  = 3'd0,
        PIN_SDATA = 3'd1,
        PIN_LE    = 3'd2,
        PIN_PLL   = 3'd3,
        PIN_DRV   = 3'd4
    } pin_idx_e;

    parameter int NPINS = 5;

    function automatic word_t reset_value(input int idx);
        word_t v;
        v = '0;
        if (idx == LO_REG) v[PLEN_BIT] = 1'b1;
        return v;
    endfunction

    function automatic logic is_freq_reg(input logic [ADDR_W-1:0] a);
        return (int'(a) < NUM_CAL_REG);
    endfunction
endpackage

// File: rtl/scb_pin_sync.sv
module scb_pin_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/scb_shifter.sv
module scb_shifter
    import scb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  sdata_s,
    input  logic  le_s,
    output load_t ld
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic             sclk_q, le_q;
    logic             sclk_rise, le_rise;
    word_t            sr;
    logic [CNT_W-1:0] cnt;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign le_rise   = le_s & ~le_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            sr     <= '0;
            cnt    <= '0;
            ld     <= '0;
        end else begin
            sclk_q   <= sclk_s;
            le_q     <= le_s;
            ld.valid <= 1'b0;
            if (le_rise) begin
                ld.valid <= 1'b1;
                ld.ok    <= (cnt == CNT_FULL);
                ld.addr  <= sr[ADDR_W-1:0];
                ld.data  <= sr;
                cnt      <= '0;
            end else if (sclk_rise) begin
                sr <= {sr[WORD_W-2:0], sdata_s};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    one_load_per_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ld.valid |=> !ld.valid);

    // R3
    le_makes_load_chk: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> ld.valid);
endmodule

// File: rtl/scb_reg_bank.sv
module scb_reg_bank
    import scb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  load_t                    ld,
    input  logic                     cal_done,
    output logic [NREG*WORD_W-1:0]   regs_flat,
    output logic                     frame_err,
    output logic                     cal_busy
);
    word_t regs [NREG];
    logic  freq_hit;

    assign freq_hit = ld.valid && ld.ok && is_freq_reg(ld.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reset_value(i);
            frame_err <= 1'b0;
            cal_busy  <= 1'b0;
        end else begin
            if (ld.valid) begin
                frame_err <= !ld.ok;
                if (ld.ok) regs[ld.addr] <= ld.data;
            end
            if (freq_hit)      cal_busy <= 1'b1;
            else if (cal_done) cal_busy <= 1'b0;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*WORD_W +: WORD_W] = regs[g];
    end

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ld.valid && ld.ok |=> regs[$past(ld.addr)] == $past(ld.data));

    // R4
    bad_frame_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        ld.valid && !ld.ok |=> $stable(regs_flat) && frame_err);

    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_busy) |-> $past(freq_hit));

    // R7
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cal_busy && cal_done && !freq_hit |=> !cal_busy);
endmodule

// File: rtl/scb_lo_route.sv
module scb_lo_route (
    input  logic pll_pin,
    input  logic drv_pin,
    input  logic plen_bit,
    input  logic ldrv_bit,
    output logic lo_internal,
    output logic lo_buf_en
);
    always_comb begin
        lo_internal = pll_pin & plen_bit;
        lo_buf_en   = lo_internal & (drv_pin | ldrv_bit);
    end
endmodule

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank
    import scb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_le,
    input  logic                   pll_en_pin,
    input  logic                   drv_en_pin,
    input  logic                   cal_done,
    output logic [NREG*WORD_W-1:0] ctrl_regs,
    output logic                   frame_err,
    output logic                   cal_busy,
    output logic                   lo_internal,
    output logic                   lo_buf_en
);
    logic [NPINS-1:0] pins_raw, pins_s;
    load_t            ld;
    word_t            lo_word;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_SCLK]  = ser_clk;
        pins_raw[PIN_SDATA] = ser_data;
        pins_raw[PIN_LE]    = ser_le;
        pins_raw[PIN_PLL]   = pll_en_pin;
        pins_raw[PIN_DRV]   = drv_en_pin;
    end

    scb_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    scb_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[PIN_SCLK]),
        .sdata_s (pins_s[PIN_SDATA]),
        .le_s    (pins_s[PIN_LE]),
        .ld      (ld)
    );

    scb_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .cal_done  (cal_done),
        .regs_flat (ctrl_regs),
        .frame_err (frame_err),
        .cal_busy  (cal_busy)
    );

    assign lo_word = ctrl_regs[LO_REG*WORD_W +: WORD_W];

    scb_lo_route u_lo (
        .pll_pin     (pins_s[PIN_PLL]),
        .drv_pin     (pins_s[PIN_DRV]),
        .plen_bit    (lo_word[PLEN_BIT]),
        .ldrv_bit    (lo_word[LDRV_BIT]),
        .lo_internal (lo_internal),
        .lo_buf_en   (lo_buf_en)
    );

    // R9
    buf_needs_int_chk: assert property (@(posedge clk) disable iff (rst)
        lo_buf_en |-> lo_internal);

    // R8
    int_needs_pin_chk: assert property (@(posedge clk) disable iff (rst)
        lo_internal |-> pins_s[PIN_PLL]);
endmodule

// File: tb/tb_serial_ctrl_bank.sv
module tb_serial_ctrl_bank;
    localparam int W = 24;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic pll_en_pin = 1'b0, drv_en_pin = 1'b0, cal_done = 1'b0;
    logic [8*W-1:0] ctrl_regs;
    logic frame_err, cal_busy, lo_internal, lo_buf_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_ctrl_bank dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .pll_en_pin(pll_en_pin), .drv_en_pin(drv_en_pin),
        .cal_done(cal_done), .ctrl_regs(ctrl_regs), .frame_err(frame_err),
        .cal_busy(cal_busy), .lo_internal(lo_internal), .lo_buf_en(lo_buf_en)
    );

    // {pll_pin, drv_pin, plen, ldrv, exp_internal, exp_buf}
    localparam logic [5:0] LO_VEC [8] = '{
        6'b0011_00, 6'b0111_00, 6'b1101_00, 6'b1010_10,
        6'b1011_11, 6'b1110_11, 6'b1000_00, 6'b1111_11
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] reg_of(input int i);
        return ctrl_regs[i*W +: W];
    endfunction

    task automatic send(input logic [31:0] val, input int nbits, input bit do_le);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = val[i];
            tick(HALF);
            ser_clk = 1'b1;
            tick(HALF);
            ser_clk = 1'b0;
        end
        tick(HALF);
        if (do_le) begin
            ser_le = 1'b1;
            tick(HALF);
            ser_le = 1'b0;
            tick(2 * HALF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R5 reset state
        for (int i = 0; i < 8; i++)
            check(reg_of(i) == ((i == 5) ? 24'h000040 : 24'h0), "R5 reset reg",
                  32'(reg_of(i)), (i == 5) ? 32'h40 : 32'h0);
        check(!cal_busy && !frame_err, "R5 reset flags", {30'd0, cal_busy, frame_err}, 0);

        // R8 R9 vector walk over LO selection
        for (int v = 0; v < 8; v++) begin
            w = 24'h5 | (24'(LO_VEC[v][3]) << 6) | (24'(LO_VEC[v][2]) << 3);
            send(32'(w), W, 1'b1);
            pll_en_pin = LO_VEC[v][5];
            drv_en_pin = LO_VEC[v][4];
            tick(6);
            check(lo_internal == LO_VEC[v][1], "R8 lo_internal", 32'(lo_internal), 32'(LO_VEC[v][1]));
            check(lo_buf_en == LO_VEC[v][0], "R9 lo_buf_en", 32'(lo_buf_en), 32'(LO_VEC[v][0]));
        end

        // R1 R2 MSB first, address in low bits, others untouched
        send(32'h5A3C1B, W, 1'b1);
        check(reg_of(3) == 24'h5A3C1B, "R1 word order reg3", 32'(reg_of(3)), 32'h5A3C1B);
        check(reg_of(7) == 0 && reg_of(4) == 0, "R2 others unchanged", 32'(reg_of(7) | reg_of(4)), 0);
        check(!cal_busy, "R6 reg3 no busy", 32'(cal_busy), 0);
        send(32'hC0FFEF, W, 1'b1);
        check(reg_of(7) == 24'hC0FFEF, "R2 reg7", 32'(reg_of(7)), 32'hC0FFEF);
        check(reg_of(3) == 24'h5A3C1B, "R2 reg3 kept", 32'(reg_of(3)), 32'h5A3C1B);

        // R3 bits shifted without load edge change nothing
        send(32'h123456, W, 1'b0);
        check(reg_of(6) == 0, "R3 no load edge", 32'(reg_of(6)), 0);
        ser_le = 1'b1; tick(HALF); ser_le = 1'b0; tick(2 * HALF);
        check(reg_of(6) == 24'h123456, "R3 load on edge", 32'(reg_of(6)), 32'h123456);

        // R4 short and long frames
        send(32'h0ABCD4, 20, 1'b1);
        check(frame_err, "R4 short err", 32'(frame_err), 1);
        check(reg_of(4) == 0, "R4 short discarded", 32'(reg_of(4)), 0);
        send(32'hF0ABCD4, 28, 1'b1);
        check(frame_err, "R4 long err", 32'(frame_err), 1);
        check(reg_of(4) == 0, "R4 long discarded", 32'(reg_of(4)), 0);
        send(32'h0ABCD4, W, 1'b1);
        check(!frame_err && reg_of(4) == 24'h0ABCD4, "R4 good clears", 32'(reg_of(4)), 32'h0ABCD4);
        check(!cal_busy, "R6 reg4 no busy", 32'(cal_busy), 0);

        // R6 R7 calibration busy
        send(32'h000100, W, 1'b1);
        check(cal_busy, "R6 reg0 busy", 32'(cal_busy), 1);
        send(32'h000201, W, 1'b1);
        check(cal_busy, "R7 restart busy", 32'(cal_busy), 1);
        cal_done = 1'b1; tick(1); cal_done = 1'b0;
        check(!cal_busy, "R7 cleared", 32'(cal_busy), 0);
        send(32'h000302, W, 1'b1);
        check(cal_busy && reg_of(2) == 24'h000302, "R6 reg2 busy", 32'(cal_busy), 1);
        cal_done = 1'b1; tick(1); cal_done = 1'b0;
        check(!cal_busy, "R7 cleared again", 32'(cal_busy), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule